// File: doc/BRIEF.md
# Rotate-and-Mask Unit

This block is a 32-bit datapath slice for an integer execution pipe. It rotates a source word left and then applies a contiguous bit mask. The mask is built from a begin index and an end index, counted from the most significant bit. In AND mode the result is the masked rotated word. In insert mode the masked rotated bits are merged into an old destination word, which keeps all of its other bits. Record forms also produce a three-flag comparison of the result against zero, ready to be written into the first condition field.

The rotate amount comes from one of two places. It can be an immediate field, or the low bits of a full register operand. A select input picks between them. Each operation is presented with `in_valid` and is captured on the next rising clock edge. The result is registered and stays unchanged while no new operation is presented.

Top module: `rotmask_unit`

## Requirements
- R1: With `amt_sel_reg`=0 the source word is rotated left by `amt_imm`, for any amount from 0 to 31. Bits leaving the MSB re-enter at the LSB.
- R2: With `amt_sel_reg`=1 the rotate amount is `amt_reg[4:0]`. Bits 31..5 of `amt_reg` have no effect on the result.
- R3: The mask is 32 bits wide and uses MSB-0 numbering: index 0 is bit 31 and index 31 is bit 0. When `mask_begin` <= `mask_end`, the mask has ones at indices `mask_begin` through `mask_end` inclusive and zeros elsewhere. For example, begin 4 and end 13 gives 0x0FFC0000.
- R4: When `mask_begin` > `mask_end`, the mask wraps around. It has ones from index `mask_begin` up to index 31, and from index 0 up to index `mask_end`. All other bits are zero.
- R5: When `insert_mode`=0 (AND mode), the result is the rotated word ANDed with the mask.
- R6: When `insert_mode`=1 (insert mode), the result takes the rotated word's bits where the mask is one, and `dst_word`'s bits where the mask is zero.
- R7: When an operation is accepted with `record`=1, `cr_update` is high in the following cycle. In that cycle exactly one of `cr_lt`, `cr_gt`, `cr_eq` is set, according to a signed compare of the result with zero. When an operation is accepted with `record`=0, `cr_update` is low in the following cycle.
- R8: An operation accepted at a rising edge appears on `result` and `out_valid` after that edge. When `in_valid` is low, `out_valid` goes low and `result` holds its value.
- R9: During reset `out_valid`, `result`, `cr_update` and all three flags are zero. Reset is asserted asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present; acts as the register enable |
| src_word | input | 32 | Word to rotate |
| dst_word | input | 32 | Old destination word, used in insert mode |
| amt_imm | input | 5 | Immediate rotate amount |
| amt_reg | input | 32 | Register operand; its low 5 bits give the amount |
| amt_sel_reg | input | 1 | 1 selects the register amount, 0 selects the immediate |
| mask_begin | input | 5 | First mask index (MSB-0) |
| mask_end | input | 5 | Last mask index (MSB-0) |
| insert_mode | input | 1 | 0 selects AND mode, 1 selects insert mode |
| record | input | 1 | Request a condition-flag update |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Rotated and masked word |
| cr_update | output | 1 | Flags below belong to the current result |
| cr_lt | output | 1 | Result is negative |
| cr_gt | output | 1 | Result is positive and non-zero |
| cr_eq | output | 1 | Result is zero |

## Verification
The bench builds the unit at its default 32-bit width, which keeps every begin/end pair within reach. All 1024 pairs are swept, with random source and destination words. The rotate amounts and the mode alternate as the sweep proceeds, so both the contiguous and the wrapped masks are checked in both modes. Separate passes cover all 32 immediate amounts, register amounts with junk in the upper bits, and the hold behaviour when no operation is presented. Record operations whose results are negative, zero and positive exercise each of the three flags.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  typedef enum logic {
    RM_AND    = 1'b0,
    RM_INSERT = 1'b1
  } rm_mode_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } rm_cr_t;
endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  // log2(W) stages; stage s rotates left by 2**s when amt[s] is set
  logic [W-1:0] stage [0:SHW];

  assign stage[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][W-1-D:0], stage[s][W-1:W-D]}
                               : stage[s];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/rm_maskgen.sv
module rm_maskgen #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [SHW-1:0] mb,
  input  logic [SHW-1:0] me,
  output logic [W-1:0]   mask
);
  logic wrap;
  assign wrap = (mb > me);

  // i is the MSB-0 index; it sits at LSB-0 position W-1-i
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SHW-1:0] IDX = SHW'(i);
    logic at_or_after_begin;
    logic at_or_before_end;
    assign at_or_after_begin = (IDX >= mb);
    assign at_or_before_end  = (IDX <= me);
    assign mask[W-1-i] = wrap ? (at_or_after_begin | at_or_before_end)
                              : (at_or_after_begin & at_or_before_end);
  end
endmodule

// File: rtl/rm_merge.sv
module rm_merge
  import rotmask_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] rot,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] dst,
  input  rm_mode_e     mode,
  output logic [W-1:0] res,
  output rm_cr_t       cr
);
  always_comb begin
    if (mode == RM_INSERT) res = (rot & mask) | (dst & ~mask);
    else                   res = rot & mask;
    cr.lt = res[W-1];
    cr.eq = (res == '0);
    cr.gt = ~res[W-1] & (res != '0);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   src_word,
  input  logic [W-1:0]   dst_word,
  input  logic [SHW-1:0] amt_imm,
  input  logic [W-1:0]   amt_reg,
  input  logic           amt_sel_reg,
  input  logic [SHW-1:0] mask_begin,
  input  logic [SHW-1:0] mask_end,
  input  logic           insert_mode,
  input  logic           record,
  output logic           out_valid,
  output logic [W-1:0]   result,
  output logic           cr_update,
  output logic           cr_lt,
  output logic           cr_gt,
  output logic           cr_eq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // amount select; upper register bits are deliberately dropped
  logic [SHW-1:0] amt_sel;
  logic           unused_amt_hi;
  assign amt_sel       = amt_sel_reg ? amt_reg[SHW-1:0] : amt_imm;
  assign unused_amt_hi = ^amt_reg[W-1:SHW];

  logic [W-1:0] rot_w, mask_w, res_w;
  rm_cr_t       cr_w;
  rm_mode_e     mode_w;
  assign mode_w = insert_mode ? RM_INSERT : RM_AND;

  rm_rotator #(.W(W), .SHW(SHW)) u_rot (
    .din(src_word), .amt(amt_sel), .dout(rot_w)
  );

  rm_maskgen #(.W(W), .SHW(SHW)) u_mask (
    .mb(mask_begin), .me(mask_end), .mask(mask_w)
  );

  rm_merge #(.W(W)) u_merge (
    .rot(rot_w), .mask(mask_w), .dst(dst_word), .mode(mode_w),
    .res(res_w), .cr(cr_w)
  );

  // next state
  logic [W-1:0] res_d, res_q;
  rm_cr_t       cr_d, cr_q;
  logic         vld_d, vld_q, upd_d, upd_q;

  always_comb begin
    vld_d = in_valid;
    upd_d = in_valid & record;
    res_d = in_valid ? res_w : res_q;
    if (in_valid && record) cr_d = cr_w;
    else if (in_valid)      cr_d = '0;
    else                    cr_d = cr_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      upd_q <= 1'b0;
      res_q <= '0;
      cr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      upd_q <= upd_d;
      res_q <= res_d;
      cr_q  <= cr_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign cr_update = upd_q;
  assign cr_lt     = cr_q.lt;
  assign cr_gt     = cr_q.gt;
  assign cr_eq     = cr_q.eq;

  // ---------------- assertions ----------------
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  a_r8_idle_drops_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(result));
  a_r5_and_clears_outside: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !insert_mode) |=> ((result & ~$past(mask_w)) == '0));
  a_r6_insert_keeps_dst: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && insert_mode) |=> (((result ^ $past(dst_word)) & ~$past(mask_w)) == '0));
  a_r3_begin_bit_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |-> mask_w[(W-1) - int'(mask_begin)]);
  a_r4_wrap_covers_ends: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (mask_begin > mask_end)) |-> (mask_w[W-1] && mask_w[0]));
  a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    cr_update |-> ($countones({cr_lt, cr_gt, cr_eq}) == 1));
  a_r7_eq_matches_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    cr_update |-> (cr_eq == (result == '0)));
  a_r7_update_tracks_record: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !record) |=> !cr_update);
endmodule

// File: tb/rotmask_unit_bench.sv
module rotmask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src_word, dst_word, amt_reg;
  logic [4:0]  amt_imm, mask_begin, mask_end;
  logic        amt_sel_reg, insert_mode, record;
  logic        out_valid, cr_update, cr_lt, cr_gt, cr_eq;
  logic [31:0] result;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  rotmask_unit u_rotmask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_word(src_word), .dst_word(dst_word),
    .amt_imm(amt_imm), .amt_reg(amt_reg), .amt_sel_reg(amt_sel_reg),
    .mask_begin(mask_begin), .mask_end(mask_end),
    .insert_mode(insert_mode), .record(record),
    .out_valid(out_valid), .result(result), .cr_update(cr_update),
    .cr_lt(cr_lt), .cr_gt(cr_gt), .cr_eq(cr_eq)
  );

  function automatic logic [31:0] ref_rot(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] ref_mask(input int mb, input int me);
    logic [31:0] a, b;
    a = 32'hFFFF_FFFF >> mb;
    b = 32'hFFFF_FFFF << (31 - me);
    return (mb <= me) ? (a & b) : (a | b);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation, sample one cycle later, compare
  task automatic run_op(input string req, input logic [31:0] s, input logic [31:0] d,
                        input int amt, input logic use_reg, input logic [31:0] regv,
                        input int mb, input int me, input logic ins, input logic rec);
    logic [31:0] m, r, e;
    @(negedge clk);
    in_valid    = 1'b1;
    src_word    = s;
    dst_word    = d;
    amt_imm     = 5'(amt);
    amt_sel_reg = use_reg;
    amt_reg     = regv;
    mask_begin  = 5'(mb);
    mask_end    = 5'(me);
    insert_mode = ins;
    record      = rec;
    @(negedge clk);
    in_valid = 1'b0;
    m = ref_mask(mb, me);
    r = ref_rot(s, use_reg ? int'(regv[4:0]) : amt);
    e = ins ? ((r & m) | (d & ~m)) : (r & m);
    check(req, result, e);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    if (rec) begin
      check("R7 flags", {29'd0, cr_update, cr_lt, cr_gt},
            {29'd0, 1'b1, e[31], (!e[31] && e != 0)});
      check("R7 eq", {31'd0, cr_eq}, {31'd0, (e == 0)});
    end else begin
      check("R7 no update", {31'd0, cr_update}, 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; in_valid = 1'b0; src_word = '0; dst_word = '0;
    amt_imm = '0; amt_reg = '0; amt_sel_reg = 1'b0; mask_begin = '0;
    mask_end = '0; insert_mode = 1'b0; record = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", {out_valid, cr_update, cr_lt, cr_gt, cr_eq}, 32'd0);
    check("R9 reset result", result, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 worked example: begin 4, end 13, rotate 5
    @(negedge clk);
    in_valid = 1'b1; src_word = 32'hFFFF_FFFF; amt_imm = 5'd5; amt_sel_reg = 1'b0;
    mask_begin = 5'd4; mask_end = 5'd13; insert_mode = 1'b0; record = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 example mask", result, 32'h0FFC_0000);
    run_op("R3 example data", 32'h1234_5678, 32'h0, 5, 1'b0, 32'h0, 4, 13, 1'b0, 1'b0);

    // R1 every immediate amount with a full mask
    for (int a = 0; a < 32; a++)
      run_op("R1 rotate", 32'h8000_0003 ^ (32'h1 << a), 32'h0, a, 1'b0, 32'h0, 0, 31, 1'b0, 1'b0);

    // R2 register amount, upper bits junk
    for (int a = 0; a < 32; a++)
      run_op("R2 reg amount", $urandom, 32'h0, 31 - a, 1'b1,
             {$urandom} & 32'hFFFF_FFE0 | 32'(a), 0, 31, 1'b0, 1'b0);

    // R3/R4/R5/R6 all begin/end pairs, both modes, random operands
    for (int mb = 0; mb < 32; mb++)
      for (int me = 0; me < 32; me++)
        run_op((mb > me) ? ((((mb + me) & 1) != 0) ? "R4 wrap R6 insert" : "R4 wrap R5 and")
                         : ((((mb + me) & 1) != 0) ? "R3 mask R6 insert" : "R3 mask R5 and"),
               $urandom, $urandom, (mb * 7 + me) % 32, 1'b0, 32'h0, mb, me,
               ((mb + me) & 1) != 0, (me % 3) == 0);

    // R7 each flag
    run_op("R7 zero", 32'h0, 32'h0, 3, 1'b0, 32'h0, 0, 31, 1'b0, 1'b1);
    run_op("R7 negative", 32'h0000_0001, 32'h0, 31, 1'b0, 32'h0, 0, 31, 1'b0, 1'b1);
    run_op("R7 positive", 32'h0000_0001, 32'h0, 4, 1'b0, 32'h0, 0, 31, 1'b0, 1'b1);
    run_op("R7 insert negative", 32'h0, 32'hF000_0000, 0, 1'b0, 32'h0, 16, 31, 1'b1, 1'b1);

    // R8 hold while idle: change inputs with in_valid low
    held = result;
    @(negedge clk);
    src_word = 32'hDEAD_BEEF; mask_begin = 5'd0; mask_end = 5'd31; amt_imm = 5'd9;
    repeat (2) @(negedge clk);
    check("R8 hold result", result, held);
    check("R8 valid low", {31'd0, out_valid}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule